// File: doc/BRIEF.md
# Interlocked Bus Read Requester

This block is the initiating side of a fully interlocked, four-phase read on a shared parallel bus. A local client pulses a start input together with a target address. The block waits for the bus to be marked free and puts the address on the bus. It then raises a request line and waits for the responder to acknowledge. Once acknowledged, it releases the address lines, drops the request and waits for the responder's ready line. It captures the data word when ready rises. It then drives the shared acknowledge wire high itself and waits for ready to fall. Last, it drives acknowledge low for one cycle and goes idle, pulsing a done flag.

Every phase advances on a level change from the far side, not on a cycle count. The responder's acknowledge and ready arrive without timing guarantees, so both pass through a two-flop synchroniser before the state machine sees them. The acknowledge wire has two drivers. The responder drives it during the address phase and the requester drives it during the data phase. For this reason the block brings out separate output-enable signals for the address lines and for acknowledge, and the surrounding logic resolves the shared wires.

Top module: `hs_read_requester`

## Requirements
- R1: After a start pulse the block is busy but enables no bus driver while the bus-free input is low. The first cycle in which it may enable the address lines is the one after bus-free is seen high.
- R2: The address lines are enabled, carrying the address sampled with the start pulse, for exactly one cycle with request low. Request then rises with the address still enabled.
- R3: Once acknowledge is seen high, request falls and the address enable falls in the same cycle.
- R4: Once ready is seen high, the data input is captured into the read-data output. In the same cycle the acknowledge enable and the acknowledge output both go high.
- R5: Once ready is seen low again, acknowledge is driven low (enable still high) for exactly one cycle, and done is high in that cycle only. In the next cycle both enables are low and busy is low.
- R6: A change of acknowledge or ready is acted on at the third rising clock edge after it, because of the two-stage synchroniser. The outputs are unchanged after the second edge.
- R7: A start pulse while busy is ignored. No second transaction follows the current one.
- R8: During reset, request, both enables, done and busy are low, and read-data is zero.
- R9: Read-data holds the captured word after the transaction until the next capture, whatever the data input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a read (sampled only when idle) |
| addr_i | input | AW | Target address, sampled with start |
| bus_free_i | input | 1 | Bus marked available |
| ack_i | input | 1 | Shared acknowledge wire as seen on the bus |
| rdy_i | input | 1 | Responder ready wire |
| data_i | input | DW | Bus data lines |
| addr_o | output | AW | Address to drive onto the bus |
| addr_oe_o | output | 1 | Address line drive enable |
| req_o | output | 1 | Request line |
| ack_o | output | 1 | Acknowledge value driven in the data phase |
| ack_oe_o | output | 1 | Acknowledge drive enable |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read data |

## Verification
A start sampled at one edge makes the block busy at that edge. The address enable comes one edge later when the bus is already free, and request one edge after that. Each far-side level change (acknowledge high, ready high, ready low) is due at the third rising edge after the bench drives it. The bench drives at falling edges and checks at the second falling edge that nothing has moved yet, and at the third that the result is present. The release of both enables follows done by exactly one edge, and the bench checks it at the very next falling edge.

// File: rtl/hs_read_requester.sv
module hs_read_requester #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          bus_free_i,
  input  logic          ack_i,
  input  logic          rdy_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe_o,
  output logic          req_o,
  output logic          ack_o,
  output logic          ack_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);

  typedef enum logic [2:0] {
    IDLE, WAIT_BUS, SETUP, REQ, WAIT_RDY, ACK_HI, ACK_LO
  } state_t;

  state_t state, nxt;
  logic [SYNC_STAGES-1:0] ack_q, rdy_q;
  logic ack_s, rdy_s;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= '0;
      rdy_q <= '0;
    end else begin
      ack_q <= {ack_q[SYNC_STAGES-2:0], ack_i};
      rdy_q <= {rdy_q[SYNC_STAGES-2:0], rdy_i};
    end
  end

  assign ack_s = ack_q[SYNC_STAGES-1];
  assign rdy_s = rdy_q[SYNC_STAGES-1];

  always_comb begin
    nxt = state;
    case (state)
      IDLE:     if (start_i)    nxt = WAIT_BUS;
      WAIT_BUS: if (bus_free_i) nxt = SETUP;
      SETUP:                    nxt = REQ;
      REQ:      if (ack_s)      nxt = WAIT_RDY;
      WAIT_RDY: if (rdy_s)      nxt = ACK_HI;
      ACK_HI:   if (!rdy_s)     nxt = ACK_LO;
      ACK_LO:                   nxt = IDLE;
      default:                  nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      state <= nxt;
      if (state == IDLE && start_i) addr_q <= addr_i;
      if (state == WAIT_RDY && rdy_s) data_q <= data_i;
    end
  end

  assign addr_o    = addr_q;
  assign addr_oe_o = (state == SETUP) || (state == REQ);
  assign req_o     = (state == REQ);
  assign ack_oe_o  = (state == ACK_HI) || (state == ACK_LO);
  assign ack_o     = (state == ACK_HI);
  assign busy_o    = (state != IDLE);
  assign done_o    = (state == ACK_LO);
  assign rdata_o   = data_q;

  assert_free_before_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_oe_o) |-> $past(bus_free_i));

  assert_addr_before_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> addr_oe_o && $past(addr_oe_o) && !$past(req_o));

  assert_release_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> !addr_oe_o);

  assert_ack_high_on_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe_o) |-> ack_o);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !ack_oe_o && !busy_o);

  assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !addr_oe_o && !ack_oe_o && !req_o);

  assert_no_dual_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_oe_o && ack_oe_o));

endmodule

// File: tb/hs_read_requester_bench.sv
module hs_read_requester_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NV = 6;

  localparam logic [AW-1:0] V_ADDR [NV] = '{16'h1234, 16'h0000, 16'hFFFF, 16'hA5A5, 16'h0F0F, 16'h8001};
  localparam logic [DW-1:0] V_DATA [NV] = '{16'hBEEF, 16'hFFFF, 16'h0000, 16'h5A5A, 16'hC3C3, 16'h7FFE};
  localparam int V_ACKDLY [NV] = '{0, 3, 1, 5, 2, 0};
  localparam int V_RDYDLY [NV] = '{0, 1, 4, 2, 0, 3};
  localparam int V_HOLD   [NV] = '{0, 0, 6, 0, 3, 0};
  localparam bit V_INJECT [NV] = '{0, 1, 0, 1, 0, 0};

  logic clk = 0, rst_n = 0, start = 0, bus_free = 1, resp_ack = 0, rdy = 0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] rdata;
  logic addr_oe, req, ack_o, ack_oe, busy, done, ack_wire;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  assign ack_wire = ack_oe ? ack_o : resp_ack;

  hs_read_requester #(.AW(AW), .DW(DW)) u_hs_read_requester (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr_i), .bus_free_i(bus_free),
    .ack_i(ack_wire), .rdy_i(rdy), .data_i(data_i), .addr_o(addr_o), .addr_oe_o(addr_oe),
    .req_o(req), .ack_o(ack_o), .ack_oe_o(ack_oe), .busy_o(busy), .done_o(done), .rdata_o(rdata));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run(input int v);
    step(1);
    addr_i = V_ADDR[v]; start = 1; bus_free = (V_HOLD[v] == 0);
    step(1);
    start = 0; addr_i = ~V_ADDR[v];
    check(busy && !addr_oe && !ack_oe, "R1 waiting", {addr_oe, ack_oe}, 0);
    if (V_HOLD[v] > 0) begin
      step(V_HOLD[v]);
      check(busy && !addr_oe && !req, "R1 bus held", addr_oe, 0);
      bus_free = 1;
    end
    step(1);
    check(addr_oe && !req, "R2 setup", {addr_oe, req}, 2'b10);
    check(addr_o == V_ADDR[v], "R2 address", addr_o, V_ADDR[v]);
    step(1);
    check(addr_oe && req, "R2 request", {addr_oe, req}, 2'b11);
    step(V_ACKDLY[v]);
    resp_ack = 1;
    step(2);
    check(req && addr_oe, "R6 ack not yet seen", {addr_oe, req}, 2'b11);
    step(1);
    check(!req && !addr_oe, "R3 release", {addr_oe, req}, 0);
    resp_ack = 0;
    data_i = V_DATA[v];
    if (V_INJECT[v]) begin
      addr_i = 16'h5555; start = 1; step(1); start = 0;
    end
    step(V_RDYDLY[v]);
    rdy = 1;
    step(2);
    check(!ack_oe, "R6 ready not yet seen", ack_oe, 0);
    step(1);
    check(ack_oe && ack_o, "R4 ack driven high", {ack_oe, ack_o}, 2'b11);
    check(rdata == V_DATA[v], "R4 capture", rdata, V_DATA[v]);
    data_i = ~V_DATA[v];
    step(1);
    rdy = 0;
    step(2);
    check(ack_oe && ack_o && !done, "R6 ready low not yet seen", {ack_oe, ack_o, done}, 3'b110);
    step(1);
    check(ack_oe && !ack_o && done, "R5 ack low and done", {ack_oe, ack_o, done}, 3'b101);
    step(1);
    check(!ack_oe && !done && !busy, "R5 release", {ack_oe, done, busy}, 0);
    check(rdata == V_DATA[v], "R9 hold", rdata, V_DATA[v]);
    step(4);
    check(!busy && !addr_oe && !req, "R7 no extra transaction", {busy, addr_oe, req}, 0);
    check(rdata == V_DATA[v], "R9 hold later", rdata, V_DATA[v]);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    start = 1; addr_i = 16'h9999; rdy = 1; resp_ack = 1; data_i = 16'h1111;
    step(3);
    check(!req && !addr_oe && !ack_oe && !done && !busy, "R8 reset outputs",
          {req, addr_oe, ack_oe, done, busy}, 0);
    check(rdata == 0, "R8 reset data", rdata, 0);
    start = 0; rdy = 0; resp_ack = 0;
    rst_n = 1;
    step(4);
    check(!busy && rdata == 0, "R8 idle after reset", {busy, rdata}, 0);
    for (int v = 0; v < NV; v++) run(v);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule